// File: doc/BRIEF.md
# DDR Auto-Precharge Bank Timing Tracker

This block sits beside the command scheduler of a DDR SDRAM controller. It watches a stream of already-decoded commands and keeps a small state machine and timer for each bank. The stream holds one command per clock: no-op, row activate, plain read or write, and read or write with auto-precharge. From this stream the block works out three things for each bank. The first is the cycle in which the implicit precharge begins. The second is the cycle from which the bank may be activated again. The third is whether a column command to it is legal in the current cycle.

A read with auto-precharge starts its precharge half a burst after the command, but never before the row-active minimum has run out. A write with auto-precharge waits four cycles more than the read does. Each auto-precharge command also opens a shared window that blocks column commands to every bank. After a read the window lasts until the burst's last data beat has left the device. After a write it lasts until the written bank has begun its precharge. Row activates to other banks are never held back by this window or by a pending precharge.

A command that breaks a rule raises a one-cycle pulse on `protocol_err` and is otherwise ignored. The scheduler uses `act_ready` and `col_ready` to pick legal commands. `prech_busy` shows which banks are in their precharge interval. The reset input asserts asynchronously and is expected to be deasserted in step with `clk`.

Top module: `ddrap_bank_tracker`

## Requirements
- R1: During and after reset, and until a command arrives, every bank reports `act_ready`=1, `col_ready`=0 and `prech_busy`=0, and `protocol_err` is 0.
- R2: An accepted activate (op code 1) to a bank drops its `act_ready` from the next cycle. That bank's `col_ready` rises in the cycle exactly T_RCD cycles after the activate cycle, as long as no column window is open. An idle bank stays idle until it receives an activate.
- R3: The burst code sets the burst length: 0 gives 2 beats (1 clock), 1 gives 4 beats (2 clocks) and 2 gives 8 beats (4 clocks). Code 3 on any column command counts as a violation, and the command is ignored.
- R4: A read with auto-precharge (op code 4) issued k cycles after its activate starts precharge in the cycle that lies max(BL/2, T_RAS-k) cycles after the command. The bank's `prech_busy` rises in that cycle. Once the command is accepted, the bank is no longer ready for activate or column commands.
- R5: A read with auto-precharge is accepted as soon as T_RCD cycles have passed since the activate, even if T_RAS has not yet elapsed.
- R6: A write with auto-precharge (op code 5) issued k cycles after its activate starts precharge max(BL/2+4, T_RAS-k) cycles after the command.
- R7: `prech_busy` stays high for exactly T_RP cycles. `act_ready` returns in the cycle T_RP cycles after the precharge start.
- R8: After a read with auto-precharge issued in cycle t, `col_ready` is 0 for every bank until cycle t+CAS_LAT+BL/2, and it returns in that cycle for banks that are open.
- R9: After a write with auto-precharge, `col_ready` is 0 for every bank until the cycle after the written bank's precharge starts.
- R10: An activate to an idle bank is accepted while another bank has a precharge pending or a column window is open.
- R11: `protocol_err` goes high for one cycle, in the cycle after the offending command. An offending command is an activate to a bank that is not idle, or a column command (op codes 2 to 5) to a bank that is not open for at least T_RCD cycles, inside a column window, or with burst code 3. Op codes 0, 6 and 7 are no-ops.
- R12: A plain read (op code 2) or write (op code 3) leaves the bank open and opens no column window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cmd_op | input | 3 | Decoded command: 0 no-op, 1 activate, 2 read, 3 write, 4 read+AP, 5 write+AP |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_burst | input | 2 | Burst length code of a column command |
| act_ready | output | NUM_BANKS | Bank is idle and may be activated |
| col_ready | output | NUM_BANKS | A column command to the bank is legal this cycle |
| prech_busy | output | NUM_BANKS | Bank is inside its implicit precharge interval |
| protocol_err | output | 1 | One-cycle pulse after a rule-breaking command |

## Verification
The bench builds the block with its defaults: 4 banks, T_RCD=3, T_RAS=7, T_RP=3 and CAS_LAT=3. It sweeps the read-to-activate distance from 3 to 8 for all three burst lengths, for both auto-precharge types, and rotates the target bank. This sweep covers both outcomes of the precharge rule. Early short reads have their precharge held back by T_RAS. Writes and eight-beat reads are governed by the burst term. The age counter saturates at the largest distances. Directed sequences then cover the violation cases, the no-op codes, plain column commands and activates issued inside an open window.

// File: rtl/ddrap_pkg.sv
package ddrap_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_RDAP = 3'd4,
    OP_WRAP = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APWAIT = 2'd2,
    BK_PRECH  = 2'd3
  } bank_st_e;

  localparam int unsigned WRITE_TAIL = 4;
  localparam logic [1:0]  BURST_BAD  = 2'd3;

  // clocks occupied by one burst on the data bus
  function automatic logic [3:0] half_burst(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/ddrap_bank_fsm.sv
module ddrap_bank_fsm
  import ddrap_pkg::*;
#(
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAS = 7,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             ap_go,
  input  logic [CNT_W-1:0] ap_delay,
  output logic             is_idle,
  output logic             col_ok,
  output logic             in_prech,
  output logic [CNT_W-1:0] ras_left
);

  localparam int unsigned AGE_W = $clog2(T_RAS + 1);

  bank_st_e         st_q, st_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic             age_en;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;

  always_comb begin
    st_d   = st_q;
    age_d  = age_q;
    age_en = 1'b0;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    case (st_q)
      BK_IDLE: begin
        if (act_go) begin
          st_d   = BK_OPEN;
          age_d  = AGE_W'(1);
          age_en = 1'b1;
        end
      end
      BK_OPEN: begin
        if (ap_go) begin
          tmr_en = 1'b1;
          if (ap_delay == CNT_W'(1)) begin
            st_d  = BK_PRECH;
            tmr_d = CNT_W'(T_RP);
          end else begin
            st_d  = BK_APWAIT;
            tmr_d = ap_delay - CNT_W'(1);
          end
        end else if (age_q != AGE_W'(T_RAS)) begin
          age_en = 1'b1;
          age_d  = age_q + AGE_W'(1);
        end
      end
      BK_APWAIT: begin
        tmr_en = 1'b1;
        if (tmr_q == CNT_W'(1)) begin
          st_d  = BK_PRECH;
          tmr_d = CNT_W'(T_RP);
        end else begin
          tmr_d = tmr_q - CNT_W'(1);
        end
      end
      default: begin
        tmr_en = 1'b1;
        if (tmr_q == CNT_W'(1)) begin
          st_d  = BK_IDLE;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q - CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (age_en) age_q <= age_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign is_idle  = (st_q == BK_IDLE);
  assign in_prech = (st_q == BK_PRECH);
  assign col_ok   = (st_q == BK_OPEN) && (age_q >= AGE_W'(T_RCD));
  assign ras_left = CNT_W'(T_RAS) - CNT_W'(age_q);

endmodule

// File: rtl/ddrap_col_window.sv
module ddrap_col_window #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             blocked
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? len : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign blocked = (cnt_q != '0);

endmodule

// File: rtl/ddrap_bank_tracker.sv
module ddrap_bank_tracker
  import ddrap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RAS     = 7,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned CAS_LAT   = 3,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [1:0]           cmd_burst,
  output logic [NUM_BANKS-1:0] act_ready,
  output logic [NUM_BANKS-1:0] col_ready,
  output logic [NUM_BANKS-1:0] prech_busy,
  output logic                 protocol_err
);

  localparam int unsigned CNT_MAX = T_RAS + T_RP + CAS_LAT + WRITE_TAIL + 8;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [NUM_BANKS-1:0] bank_idle, bank_col_ok, bank_prech;
  logic [CNT_W-1:0]     ras_left [NUM_BANKS];
  logic [NUM_BANKS-1:0] act_go, ap_go;

  logic             is_act, is_col, is_ap, is_wr_ap;
  logic             sel_idle, sel_ok, bad_burst, blocked, bad, accept;
  logic [CNT_W-1:0] hb, sel_ras, rd_delay, wr_delay, ap_delay, win_len;
  logic             err_q;

  // command decode
  always_comb begin
    is_act    = (cmd_op == OP_ACT);
    is_wr_ap  = (cmd_op == OP_WRAP);
    is_ap     = (cmd_op == OP_RDAP) || is_wr_ap;
    is_col    = (cmd_op == OP_RD) || (cmd_op == OP_WR) || is_ap;
    bad_burst = (cmd_burst == BURST_BAD);
    sel_idle  = bank_idle[cmd_bank];
    sel_ok    = bank_col_ok[cmd_bank];
    sel_ras   = ras_left[cmd_bank];
  end

  // legality and implicit precharge delay
  always_comb begin
    hb       = CNT_W'(half_burst(cmd_burst));
    rd_delay = (hb >= sel_ras) ? hb : sel_ras;
    wr_delay = ((hb + CNT_W'(WRITE_TAIL)) >= sel_ras) ? (hb + CNT_W'(WRITE_TAIL)) : sel_ras;
    ap_delay = is_wr_ap ? wr_delay : rd_delay;
    win_len  = is_wr_ap ? wr_delay : (CNT_W'(CAS_LAT) + hb - CNT_W'(1));
    bad      = (is_act && !sel_idle) ||
               (is_col && (!sel_ok || blocked || bad_burst));
    accept   = !bad;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit       = (cmd_bank == BANK_W'(g));
    assign act_go[g] = accept && is_act && hit;
    assign ap_go[g]  = accept && is_ap && hit;

    ddrap_bank_fsm #(
      .T_RCD (T_RCD),
      .T_RAS (T_RAS),
      .T_RP  (T_RP),
      .CNT_W (CNT_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_go   (act_go[g]),
      .ap_go    (ap_go[g]),
      .ap_delay (ap_delay),
      .is_idle  (bank_idle[g]),
      .col_ok   (bank_col_ok[g]),
      .in_prech (bank_prech[g]),
      .ras_left (ras_left[g])
    );
  end

  ddrap_col_window #(
    .CNT_W (CNT_W)
  ) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && is_ap),
    .len     (win_len),
    .blocked (blocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad;
  end

  assign act_ready    = bank_idle;
  assign col_ready    = blocked ? '0 : bank_col_ok;
  assign prech_busy   = bank_prech;
  assign protocol_err = err_q;

endmodule

// File: rtl/ddrap_bank_tracker_chk.sv
module ddrap_bank_tracker_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_op,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [1:0]           cmd_burst,
  input logic [NUM_BANKS-1:0] act_ready,
  input logic [NUM_BANKS-1:0] col_ready,
  input logic [NUM_BANKS-1:0] prech_busy,
  input logic                 protocol_err
);

  logic col_cmd, ap_b0;
  assign col_cmd = (cmd_op >= 3'd2) && (cmd_op <= 3'd5);
  assign ap_b0   = ((cmd_op == 3'd4) || (cmd_op == 3'd5)) && (cmd_bank == '0) &&
                   col_ready[0] && (cmd_burst != 2'd3);

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_err |-> ($past(cmd_op) >= 3'd1 && $past(cmd_op) <= 3'd5)); // R11
  AST_ACT_BUSY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && !act_ready[cmd_bank]) |=> protocol_err); // R11
  AST_ACT_IDLE_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && act_ready[cmd_bank]) |=> !protocol_err); // R10
  AST_COL_UNREADY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (col_cmd && !col_ready[cmd_bank]) |=> protocol_err); // R8
  AST_PRECH_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prech_busy[0]) |-> act_ready[0]); // R7
  AST_AP_CLOSES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    ap_b0 |=> (!act_ready[0] && !col_ready[0])); // R4
  AST_WR_AP_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_b0 && cmd_op == 3'd5) |=> !prech_busy[0]); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ready[0] && !(cmd_op == 3'd1 && cmd_bank == '0)) |=> act_ready[0]); // R2

endmodule

bind ddrap_bank_tracker ddrap_bank_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_op       (cmd_op),
  .cmd_bank     (cmd_bank),
  .cmd_burst    (cmd_burst),
  .act_ready    (act_ready),
  .col_ready    (col_ready),
  .prech_busy   (prech_busy),
  .protocol_err (protocol_err)
);

// File: tb/ddrap_bank_tracker_tb.sv
module ddrap_bank_tracker_tb;

  localparam int NB = 4, TRCD = 3, TRAS = 7, TRP = 3, CL = 3;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_RDAP = 3'd4, C_WRAP = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_bank;
  logic [1:0]    cmd_burst;
  logic [NB-1:0] act_ready, col_ready, prech_busy;
  logic          protocol_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ddrap_bank_tracker u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_op (cmd_op), .cmd_bank (cmd_bank),
    .cmd_burst (cmd_burst), .act_ready (act_ready), .col_ready (col_ready),
    .prech_busy (prech_busy), .protocol_err (protocol_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive a command for the current cycle, then move 1 ns past the next edge
  task automatic step(input logic [2:0] op, input int bk, input int bc);
    cmd_op = op; cmd_bank = 2'(bk); cmd_burst = 2'(bc);
    @(posedge clk); #1;
    cmd_op = C_NOP;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_op = C_NOP; cmd_bank = '0; cmd_burst = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(act_ready == 4'hF, "R1 act_ready", int'(act_ready), 15);
    chk(col_ready == 4'h0, "R1 col_ready", int'(col_ready), 0);
    chk(prech_busy == 4'h0 && !protocol_err, "R1 prech/err", int'(prech_busy), 0);

    // sweep: burst code x activate distance x read/write auto-precharge
    for (int wr = 0; wr < 2; wr++) begin
      for (int bc = 0; bc < 3; bc++) begin
        for (int k = TRCD; k <= TRAS + 1; k++) begin
          int b, o, hb, age, left, base, p, a, c;
          int fp, fa, fc, pcnt;
          bit errseen;
          b = (wr * 18 + bc * 6 + k) % NB;
          o = (b + 1) % NB;
          hb = (bc == 0) ? 1 : (bc == 1) ? 2 : 4;
          age = (k > TRAS) ? TRAS : k;
          left = TRAS - age;
          base = wr ? hb + 4 : hb;
          p = (base > left) ? base : left;
          a = p + TRP;
          c = wr ? p + 1 : CL + hb;
          do_reset();
          step(C_ACT, o, 0);
          step(C_ACT, b, 0);
          for (int s = 1; s < k; s++) begin
            if (s == TRCD - 1)
              chk(col_ready[b] == 1'b0, "R2 col_ready early", int'(col_ready[b]), 0);
            step(C_NOP, 0, 0);
          end
          chk(col_ready[b] == 1'b1, "R2 col_ready at T_RCD", int'(col_ready[b]), 1);
          chk(act_ready[b] == 1'b0, "R2 act_ready after ACT", int'(act_ready[b]), 0);
          step(wr ? C_WRAP : C_RDAP, b, bc);
          fp = -1; fa = -1; fc = -1; pcnt = 0; errseen = 1'b0;
          for (int j = 1; j <= 30; j++) begin
            if (prech_busy[b]) begin
              pcnt++;
              if (fp < 0) fp = j;
            end
            if (act_ready[b] && fa < 0) fa = j;
            if (col_ready[o] && fc < 0) fc = j;
            if (protocol_err) errseen = 1'b1;
            step(C_NOP, 0, 0);
          end
          if (wr) begin
            chk(fp == p, "R6 precharge start", fp, p);
            chk(fc == c, "R9 column window end", fc, c);
            chk(!errseen, "R6 accepted", int'(errseen), 0);
          end else begin
            chk(fp == p, "R4 precharge start", fp, p);
            chk(fc == c, "R8 column window end", fc, c);
            chk(!errseen, "R5 early read accepted", int'(errseen), 0);
          end
          chk(fa == a, "R7 activate ready", fa, a);
          chk(pcnt == TRP, "R7 precharge length", pcnt, TRP);
        end
      end
    end

    // R3 / R11: bad burst code ignored, one-cycle error
    do_reset();
    step(C_ACT, 0, 0);
    step(C_NOP, 0, 0);
    step(C_NOP, 0, 0);
    step(C_RDAP, 0, 3);
    chk(protocol_err == 1'b1, "R11 bad burst flagged", int'(protocol_err), 1);
    chk(col_ready[0] == 1'b1, "R3 bad burst ignored", int'(col_ready[0]), 1);
    chk(prech_busy == 4'h0, "R3 no precharge", int'(prech_busy), 0);
    step(C_NOP, 0, 0);
    chk(protocol_err == 1'b0, "R11 pulse length", int'(protocol_err), 0);

    // R11: early column, activate to open bank, column to idle bank, no-op codes
    do_reset();
    step(C_ACT, 0, 0);
    step(C_RD, 0, 1);
    chk(protocol_err == 1'b1, "R11 column before T_RCD", int'(protocol_err), 1);
    step(C_ACT, 0, 0);
    chk(protocol_err == 1'b1, "R11 activate open bank", int'(protocol_err), 1);
    step(C_WR, 1, 1);
    chk(protocol_err == 1'b1, "R11 column to idle bank", int'(protocol_err), 1);
    step(3'd6, 0, 0);
    chk(protocol_err == 1'b0, "R11 code 6 no-op", int'(protocol_err), 0);
    step(3'd7, 2, 0);
    chk(protocol_err == 1'b0 && act_ready[2], "R11 code 7 no-op", int'(protocol_err), 0);

    // R12: plain read and write keep banks open, open no window
    do_reset();
    step(C_ACT, 0, 0);
    step(C_ACT, 1, 0);
    step(C_NOP, 0, 0);
    step(C_NOP, 0, 0);
    step(C_RD, 0, 2);
    chk(protocol_err == 1'b0, "R12 plain read accepted", int'(protocol_err), 0);
    chk(col_ready == 4'b0011, "R12 no window after read", int'(col_ready), 3);
    chk(act_ready[0] == 1'b0 && prech_busy[0] == 1'b0, "R12 bank stays open",
        int'(act_ready[0]), 0);
    step(C_WR, 1, 2);
    chk(col_ready == 4'b0011 && !protocol_err, "R12 no window after write",
        int'(col_ready), 3);

    // R10 / R8: activate inside a read window, column inside it rejected
    do_reset();
    step(C_ACT, 0, 0);
    step(C_ACT, 2, 0);
    step(C_NOP, 0, 0);
    step(C_NOP, 0, 0);
    step(C_RDAP, 0, 1);
    step(C_ACT, 1, 0);
    chk(protocol_err == 1'b0, "R10 activate in window", int'(protocol_err), 0);
    chk(act_ready[1] == 1'b0, "R10 bank opened", int'(act_ready[1]), 0);
    step(C_RD, 2, 1);
    chk(protocol_err == 1'b1, "R8 column in window rejected", int'(protocol_err), 1);
    step(C_ACT, 3, 0);
    chk(protocol_err == 1'b0 && act_ready[3] == 1'b0, "R10 activate during pending precharge",
        int'(protocol_err), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule